// File: doc/BRIEF.md
# PHY Firmware Readiness Sequencer

This block decides when the embedded microcontroller inside an external PHY has finished booting. It polls two management registers of the PHY through a simple request/response register port, which stands in front of a serial management master. The serial protocol and the PHY itself lie outside the block. After a start pulse it waits for a free-running 8-bit heartbeat counter to move. It then waits for a firmware status byte to reach a threshold. All timing counts pulses of a one-millisecond tick input.

If the status byte does not reach the threshold in time, the sequencer restarts the microcontroller once. It does this with a pair of register writes and a short pause, and then runs both waits again. The sequence ends in one of three ways: done, a timeout error, or a read error. Whichever result is reached is held until software issues the next start.

Top module: `fw_ready_seq`

## Requirements
- R1: In reset, and until the first start, `busy`, `done`, `err` and `req_valid` are low. A one-cycle `start` seen while idle raises `busy` one cycle later and clears `done`, `err` and `err_code`. A `start` seen while busy has no effect on the access sequence or on the result.
- R2: Heartbeat reads use device `PCS_DEV` (default 3) and address `HB_ADDR` (default 0xD7EE), and only the low 8 bits of the response are used. The first nonzero sample becomes the reference value, and a zero sample never does. The heartbeat stage passes on the first later sample that differs from the reference.
- R3: After a failed heartbeat sample, the block waits `POLL_MS` ticks and then reads again. When a failed sample is taken and at least `HB_TIMEOUT_MS` ticks have passed since the stage began, the sequence ends with a timeout.
- R4: Status reads use address `ST_ADDR` (default 0xD7FD) on the same device. The stage passes when the low byte is at least `ST_THRESH` (default 0x20), and the sequence then ends with `done`.
- R5: After a failed status sample, the block waits `POLL_MS` ticks and then reads again. When a failed sample is taken and at least `ST_TIMEOUT_MS` ticks have passed since the stage began, the status stage has timed out.
- R6: The first status timeout triggers two writes to `RST_ADDR` (default 0xE854): 0x00C0 first, then 0x0040. The block then pauses for exactly `RESTART_MS` ticks and runs the heartbeat stage again from a cleared reference, followed by the status stage.
- R7: A status timeout after the restart, or a heartbeat timeout in either attempt, ends the sequence with `err` and `err_code` = 2'b01.
- R8: A response with `rsp_err` set ends the sequence at once with `err` and `err_code` = 2'b10, and no further request is issued.
- R9: Only one access is outstanding at a time. While `req_valid` is high and `req_ready` is low, the request and all its fields stay unchanged.
- R10: On success, `done` is 1 and `err_code` is 2'b00. `done`, `err` and `err_code` are never set together with `busy`, and they hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that starts the sequence from idle |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Firmware is ready (held) |
| err | output | 1 | Sequence failed (held) |
| err_code | output | 2 | 01 timeout, 10 read error, 00 on success |
| req_valid | output | 1 | Register access request valid |
| req_ready | input | 1 | Request accepted by the management master |
| req_dev | output | DEV_W | Target device number |
| req_addr | output | ADDR_W | Register address |
| req_wdata | output | DATA_W | Write data |
| req_write | output | 1 | 1 = write, 0 = read |
| rsp_valid | input | 1 | Response valid |
| rsp_data | input | DATA_W | Read data |
| rsp_err | input | 1 | Access failed |

## Verification
The in-RTL assertions check, on every cycle, the properties that hold locally: stable requests while stalled, the legal read targets, write targets and write values, the effect of a start on the outputs, exclusive and held results, and that no request follows an error. Other behaviour depends on sequences of PHY responses, and only the bench scenarios can show it. This covers zero samples being refused as a reference, the exact count of polls before each timeout, the threshold edge at 0x1F and 0x20, the single restart with its tick-accurate pause and fresh reference, and the abort on an error response. The bench checks these through the exact order of accesses and the final result.

// File: rtl/fwseq_pkg.sv
`timescale 1ns/1ps
package fwseq_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_HB_RD, S_HB_WAIT, S_ST_RD, S_ST_WAIT,
    S_RS_WA, S_RS_WB, S_RS_PAUSE
  } seq_state_t;

  typedef enum logic [1:0] {A_IDLE, A_REQ, A_RSP} acc_state_t;

  typedef enum logic [1:0] {
    RES_OK      = 2'b00,
    RES_TIMEOUT = 2'b01,
    RES_RDERR   = 2'b10
  } seq_result_t;
endpackage

// File: rtl/fwseq_tick_count.sv
`timescale 1ns/1ps
module fwseq_tick_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] count
);
  // saturating count of tick pulses since the last clear
  always_ff @(posedge clk) begin
    if (rst || clr)                  count <= '0;
    else if (tick && (count != '1))  count <= count + 1'b1;
  end
endmodule

// File: rtl/fwseq_reg_access.sv
`timescale 1ns/1ps
module fwseq_reg_access
  import fwseq_pkg::*;
#(
  parameter int DEV_W  = 5,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [DEV_W-1:0]  go_dev,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [DATA_W-1:0] go_wdata,
  input  logic              go_write,
  output logic              acc_idle,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [DEV_W-1:0]  req_dev,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  output logic              req_write,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              rsp_err,
  output logic              cpl,
  output logic [DATA_W-1:0] cpl_data,
  output logic              cpl_err
);
  acc_state_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= A_IDLE;
      req_valid <= 1'b0;
      req_dev   <= '0;
      req_addr  <= '0;
      req_wdata <= '0;
      req_write <= 1'b0;
    end else begin
      unique case (st)
        A_IDLE: if (go) begin
          req_valid <= 1'b1;
          req_dev   <= go_dev;
          req_addr  <= go_addr;
          req_wdata <= go_wdata;
          req_write <= go_write;
          st        <= A_REQ;
        end
        A_REQ: if (req_ready) begin
          req_valid <= 1'b0;
          st        <= A_RSP;
        end
        A_RSP: if (rsp_valid) st <= A_IDLE;
        default: st <= A_IDLE;
      endcase
    end
  end

  assign acc_idle = (st == A_IDLE);
  assign cpl      = (st == A_RSP) && rsp_valid;
  assign cpl_data = rsp_data;
  assign cpl_err  = rsp_err;

  // R9: a stalled request keeps every field
  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) &&
      $stable(req_wdata) && $stable(req_write) && $stable(req_dev));

  // R9: the sequencer launches an access only when none is outstanding
  p_go_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
    go |-> (st == A_IDLE) && !req_valid);
endmodule

// File: rtl/fw_ready_seq.sv
`timescale 1ns/1ps
module fw_ready_seq
  import fwseq_pkg::*;
#(
  parameter int          DEV_W         = 5,
  parameter int          ADDR_W        = 16,
  parameter int          DATA_W        = 16,
  parameter int          POLL_MS       = 100,
  parameter int          HB_TIMEOUT_MS = 5000,
  parameter int          ST_TIMEOUT_MS = 2500,
  parameter int          RESTART_MS    = 50,
  parameter logic [DEV_W-1:0]  PCS_DEV = 5'd3,
  parameter logic [ADDR_W-1:0] HB_ADDR = 16'hD7EE,
  parameter logic [ADDR_W-1:0] ST_ADDR = 16'hD7FD,
  parameter logic [ADDR_W-1:0] RST_ADDR = 16'hE854,
  parameter logic [DATA_W-1:0] RST_WORD_A = 16'h00C0,
  parameter logic [DATA_W-1:0] RST_WORD_B = 16'h0040,
  parameter logic [7:0]        ST_THRESH  = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ms_tick,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [1:0]        err_code,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [DEV_W-1:0]  req_dev,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  output logic              req_write,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              rsp_err
);
  localparam int TO_MAX = (HB_TIMEOUT_MS > ST_TIMEOUT_MS) ? HB_TIMEOUT_MS : ST_TIMEOUT_MS;
  localparam int PW_MAX = (POLL_MS > RESTART_MS) ? POLL_MS : RESTART_MS;
  localparam int EW     = $clog2(TO_MAX + 1);
  localparam int PW     = $clog2(PW_MAX + 1);

  seq_state_t        state, nxt;
  seq_result_t       fin_code;
  logic              fin, go, go_write, acc_sent, acc_idle, second_try;
  logic              cpl, cpl_err, hb_ok, hb_pass, elap_clr, poll_clr;
  logic [ADDR_W-1:0] go_addr;
  logic [DATA_W-1:0] go_wdata, cpl_data;
  logic [BYTE_W-1:0] hb_ref, smp;
  logic [EW-1:0]     elapsed;
  logic [PW-1:0]     poll_cnt;
  logic [DATA_W-BYTE_W-1:0] unused_hi;

  assign smp       = cpl_data[BYTE_W-1:0];
  assign unused_hi = cpl_data[DATA_W-1:BYTE_W];
  assign hb_pass   = hb_ok && (smp != hb_ref);

  fwseq_reg_access #(.DEV_W(DEV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_acc (
    .clk, .rst, .go, .go_dev(PCS_DEV), .go_addr, .go_wdata, .go_write,
    .acc_idle, .req_valid, .req_ready, .req_dev, .req_addr, .req_wdata,
    .req_write, .rsp_valid, .rsp_data, .rsp_err, .cpl, .cpl_data, .cpl_err);

  fwseq_tick_count #(.W(EW)) u_elapsed (
    .clk, .rst, .clr(elap_clr), .tick(ms_tick), .count(elapsed));

  fwseq_tick_count #(.W(PW)) u_poll (
    .clk, .rst, .clr(poll_clr), .tick(ms_tick), .count(poll_cnt));

  always_comb begin
    nxt      = state;
    go       = 1'b0;
    go_write = 1'b0;
    go_addr  = HB_ADDR;
    go_wdata = '0;
    fin      = 1'b0;
    fin_code = RES_OK;
    unique case (state)
      S_IDLE: if (start) nxt = S_HB_RD;
      S_HB_RD: begin
        go = !acc_sent && acc_idle;
        if (cpl) begin
          if (cpl_err) begin fin = 1'b1; fin_code = RES_RDERR; nxt = S_IDLE; end
          else if (hb_pass) nxt = S_ST_RD;
          else if (elapsed >= EW'(HB_TIMEOUT_MS)) begin
            fin = 1'b1; fin_code = RES_TIMEOUT; nxt = S_IDLE;
          end else nxt = S_HB_WAIT;
        end
      end
      S_HB_WAIT: if (ms_tick && poll_cnt == PW'(POLL_MS - 1)) nxt = S_HB_RD;
      S_ST_RD: begin
        go      = !acc_sent && acc_idle;
        go_addr = ST_ADDR;
        if (cpl) begin
          if (cpl_err) begin fin = 1'b1; fin_code = RES_RDERR; nxt = S_IDLE; end
          else if (smp >= ST_THRESH) begin fin = 1'b1; nxt = S_IDLE; end
          else if (elapsed >= EW'(ST_TIMEOUT_MS)) begin
            if (second_try) begin fin = 1'b1; fin_code = RES_TIMEOUT; nxt = S_IDLE; end
            else nxt = S_RS_WA;
          end else nxt = S_ST_WAIT;
        end
      end
      S_ST_WAIT: if (ms_tick && poll_cnt == PW'(POLL_MS - 1)) nxt = S_ST_RD;
      S_RS_WA, S_RS_WB: begin
        go       = !acc_sent && acc_idle;
        go_write = 1'b1;
        go_addr  = RST_ADDR;
        go_wdata = (state == S_RS_WA) ? RST_WORD_A : RST_WORD_B;
        if (cpl) begin
          if (cpl_err) begin fin = 1'b1; fin_code = RES_RDERR; nxt = S_IDLE; end
          else nxt = (state == S_RS_WA) ? S_RS_WB : S_RS_PAUSE;
        end
      end
      S_RS_PAUSE: if (ms_tick && poll_cnt == PW'(RESTART_MS - 1)) nxt = S_HB_RD;
      default: nxt = S_IDLE;
    endcase
  end

  assign elap_clr = (nxt == S_HB_RD && !(state inside {S_HB_RD, S_HB_WAIT})) ||
                    (nxt == S_ST_RD && !(state inside {S_ST_RD, S_ST_WAIT}));
  assign poll_clr = (nxt != state) && (nxt inside {S_HB_WAIT, S_ST_WAIT, S_RS_PAUSE});

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      acc_sent   <= 1'b0;
      second_try <= 1'b0;
      hb_ref     <= '0;
      hb_ok      <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      err_code   <= RES_OK;
    end else begin
      state <= nxt;
      busy  <= (nxt != S_IDLE);
      if (go)       acc_sent <= 1'b1;
      else if (cpl) acc_sent <= 1'b0;
      if (state == S_IDLE && start) begin
        done <= 1'b0; err <= 1'b0; err_code <= RES_OK; second_try <= 1'b0;
      end
      if (state == S_ST_RD && nxt == S_RS_WA) second_try <= 1'b1;
      if (elap_clr && nxt == S_HB_RD) hb_ok <= 1'b0;
      else if (state == S_HB_RD && cpl && !cpl_err && !hb_ok && smp != '0) begin
        hb_ref <= smp;
        hb_ok  <= 1'b1;
      end
      if (fin) begin
        done     <= (fin_code == RES_OK);
        err      <= (fin_code != RES_OK);
        err_code <= fin_code;
      end
    end
  end

  // R1: an accepted start raises busy and clears the previous result
  p_start_clears_r1: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> busy && !done && !err && err_code == RES_OK);

  // R10: results are exclusive and never coexist with busy
  p_result_excl_r10: assert property (@(posedge clk) disable iff (rst)
    (done || err) |-> !busy && !(done && err) && (done == (err_code == RES_OK)));

  // R10: a result holds until the next start
  p_result_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (done || err) && !start |=> $stable(done) && $stable(err) && $stable(err_code));

  // R2 / R4: reads only target the two monitored registers
  p_read_target_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_write |-> req_dev == PCS_DEV &&
      (req_addr == HB_ADDR || req_addr == ST_ADDR));

  // R6: writes only restart the microcontroller
  p_write_restart_r6: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_write |-> req_addr == RST_ADDR &&
      (req_wdata == RST_WORD_A || req_wdata == RST_WORD_B));

  // R8: nothing is requested once an error is reported
  p_no_req_after_err_r8: assert property (@(posedge clk) disable iff (rst)
    err |-> !req_valid);
endmodule

// File: tb/fw_ready_seq_tb.sv
`timescale 1ns/1ps
module fw_ready_seq_tb;
  localparam int POLL = 4, HBTO = 20, STTO = 10, RSW = 3;
  localparam logic [15:0] HB_A = 16'hD7EE, ST_A = 16'hD7FD, RS_A = 16'hE854;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, ms_tick = 1'b0;
  logic req_ready = 1'b0, rsp_valid = 1'b0, rsp_err = 1'b0;
  logic [15:0] rsp_data = '0;
  logic busy, done, err, req_valid, req_write;
  logic [1:0] err_code;
  logic [4:0] req_dev;
  logic [15:0] req_addr, req_wdata;

  always #2.5 clk = ~clk;

  fw_ready_seq #(.POLL_MS(POLL), .HB_TIMEOUT_MS(HBTO), .ST_TIMEOUT_MS(STTO),
                 .RESTART_MS(RSW)) u_dut (
    .clk, .rst, .start, .ms_tick, .busy, .done, .err, .err_code,
    .req_valid, .req_ready, .req_dev, .req_addr, .req_wdata, .req_write,
    .rsp_valid, .rsp_data, .rsp_err);

  int checks = 0, fails = 0;
  bit finished = 0;
  string cur_tag = "R2";
  logic [32:0] exp_q[$];
  logic [7:0] hb_arr[16], st_arr[16];
  int hb_len, st_len, hb_i, st_i, acc_n, err_at = -1;
  int cyc = 0, ticks_since = 0, rsp_delay = 0;
  bit after_wr = 0, prev_stall = 0;
  logic [32:0] prev_req;
  logic [15:0] pend_data;
  logic pend_err;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic void push_rd(input logic [15:0] a);
    exp_q.push_back({1'b0, a, 16'h0000});
  endfunction
  function automatic void push_wr(input logic [15:0] d);
    exp_q.push_back({1'b1, RS_A, d});
  endfunction

  // monitor + PHY model: handshakes are evaluated at the negedge before the sampling edge
  task automatic on_access();
    logic [32:0] got, e;
    logic [7:0] v;
    got = {req_write, req_addr, req_write ? req_wdata : 16'h0000};
    chk(req_dev == 5'd3, "R2", "device field", req_dev, 3);
    if (exp_q.size() == 0) chk(1'b0, cur_tag, "unexpected access", got, 0);
    else begin
      e = exp_q.pop_front();
      chk(got == e, cur_tag, "access order", got, e);
    end
    if (after_wr && !req_write) begin
      chk(ticks_since == RSW, "R6", "restart pause ticks", ticks_since, RSW);
      after_wr = 0;
    end
    if (req_write) begin ticks_since = 0; after_wr = 1; end
    pend_err = (acc_n == err_at);
    acc_n++;
    if (req_write) pend_data = 16'h0000;
    else if (req_addr == HB_A) begin
      v = hb_arr[(hb_i < hb_len) ? hb_i : hb_len - 1]; hb_i++;
      pend_data = {8'hA5, v};
    end else begin
      v = st_arr[(st_i < st_len) ? st_i : st_len - 1]; st_i++;
      pend_data = {8'h5A, v};
    end
    rsp_delay = 2;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rsp_valid) begin rsp_valid = 1'b0; rsp_err = 1'b0; end
    if (rsp_delay > 0) begin
      rsp_delay--;
      if (rsp_delay == 0) begin rsp_valid = 1'b1; rsp_data = pend_data; rsp_err = pend_err; end
    end
    if (prev_stall)  // R9: stalled request must be unchanged
      chk(req_valid && {req_write, req_addr, req_wdata} == prev_req, "R9", "stalled request",
          {req_write, req_addr, req_wdata}, prev_req);
    req_ready = (cyc % 3) != 0;
    prev_stall = !rst && req_valid && !req_ready;
    prev_req = {req_write, req_addr, req_wdata};
    if (!rst && req_valid && req_ready) on_access();
    ms_tick = (cyc % 20 == 0);
    if (ms_tick) ticks_since++;
  end

  task automatic run(input int exp_code, input bit mid_start);
    int n;
    hb_i = 0; st_i = 0; acc_n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && !done && !err, "R1", "busy after start", {busy, done, err}, 3'b100);
    if (mid_start) begin
      repeat (60) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    n = 0;
    while (!(done || err) && n < 20000) begin @(negedge clk); n++; end
    chk(n < 20000, cur_tag, "sequence finished", n, 0);
    chk(err_code == exp_code[1:0], cur_tag, "result code", err_code, exp_code);
    chk(done == (exp_code == 0) && err == (exp_code != 0) && !busy, "R10", "result flags",
        {done, err, busy}, {exp_code == 0, exp_code != 0, 1'b0});
    chk(exp_q.size() == 0, cur_tag, "missing accesses", exp_q.size(), 0);
    repeat (40) @(negedge clk);
    chk(err_code == exp_code[1:0] && (done || err) && !busy && !req_valid, "R10",
        "result held", {done, err, err_code}, exp_code);
    exp_q.delete();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!busy && !done && !err && !req_valid, "R1", "reset state",
        {busy, done, err, req_valid}, 0);
    rst = 1'b0;
    repeat (7) @(negedge clk);

    // A: zero samples refused as reference, threshold edge 0x1F/0x20, stray start ignored
    cur_tag = "R4";
    hb_arr[0] = 8'h00; hb_arr[1] = 8'h00; hb_arr[2] = 8'h07; hb_arr[3] = 8'h07; hb_arr[4] = 8'h09;
    hb_len = 5;
    st_arr[0] = 8'h00; st_arr[1] = 8'h1F; st_arr[2] = 8'h20; st_len = 3;
    repeat (5) push_rd(HB_A);
    repeat (3) push_rd(ST_A);
    run(0, 1'b1);
    chk(hb_i == 5, "R2", "heartbeat reads", hb_i, 5);

    // B: constant heartbeat -> timeout after HBTO/POLL+1 reads
    cur_tag = "R3";
    hb_arr[0] = 8'h33; hb_len = 1;
    repeat (HBTO / POLL + 1) push_rd(HB_A);
    run(1, 1'b0);
    chk(hb_i == HBTO / POLL + 1, "R3", "heartbeat polls before timeout", hb_i, HBTO / POLL + 1);

    // C: status times out once, restart, fresh reference, then ready
    cur_tag = "R6";
    hb_arr[0] = 8'h01; hb_arr[1] = 8'h02; hb_arr[2] = 8'h02; hb_arr[3] = 8'h03; hb_len = 4;
    for (int i = 0; i < 4; i++) st_arr[i] = 8'h05;
    st_arr[4] = 8'h40; st_len = 5;
    push_rd(HB_A); push_rd(HB_A);
    repeat (STTO / POLL + 2) push_rd(ST_A);
    push_wr(16'h00C0); push_wr(16'h0040);
    push_rd(HB_A); push_rd(HB_A); push_rd(ST_A);
    run(0, 1'b0);

    // D: status times out in both attempts
    cur_tag = "R7";
    hb_arr[0] = 8'h01; hb_arr[1] = 8'h02; hb_arr[2] = 8'h03; hb_arr[3] = 8'h04; hb_len = 4;
    st_arr[0] = 8'h10; st_len = 1;
    push_rd(HB_A); push_rd(HB_A);
    repeat (STTO / POLL + 2) push_rd(ST_A);
    push_wr(16'h00C0); push_wr(16'h0040);
    push_rd(HB_A); push_rd(HB_A);
    repeat (STTO / POLL + 2) push_rd(ST_A);
    run(1, 1'b0);
    chk(st_i == 2 * (STTO / POLL + 2), "R5", "status polls per attempt", st_i, 2 * (STTO / POLL + 2));

    // E: heartbeat stalls after the restart
    cur_tag = "R7";
    hb_arr[0] = 8'h01; hb_arr[1] = 8'h02; hb_len = 2;
    push_rd(HB_A); push_rd(HB_A);
    repeat (STTO / POLL + 2) push_rd(ST_A);
    push_wr(16'h00C0); push_wr(16'h0040);
    repeat (HBTO / POLL + 1) push_rd(HB_A);
    run(1, 1'b0);

    // F: error response on the first status read aborts
    cur_tag = "R8";
    hb_arr[0] = 8'h04; hb_arr[1] = 8'h05; hb_len = 2;
    err_at = 2;
    push_rd(HB_A); push_rd(HB_A); push_rd(ST_A);
    run(2, 1'b0);
    chk(acc_n == 3, "R8", "accesses after error", acc_n, 3);
    err_at = -1;

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired in %s actual=running expected=finished", cur_tag);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule